// File: doc/BRIEF.md
# Bidirectional Latch-Register Bus Transceiver

This block moves an 18-bit word between two ports, A and B. Each direction has its own path. Each path holds one storage element. That element works as a transparent latch while its latch-enable input is high. While latch-enable is low, it works as a register loaded by the rising edge of its own capture clock. Each path also has an output enable that tells the far port whether to drive the bus. The enable for the A-to-B path is active high. The enable for the B-to-A path is active low.

The block is built as synchronous logic on a system clock. The capture clock and latch-enable inputs are sampled on that clock. A capture-clock rising edge is a sampled low followed by a current high. Data, output and drive-enable are separate signals for each port. Tri-state pads, if any, sit outside the block and are controlled by the drive-enable outputs.

Top module: `xcvr_top`

## Requirements
- R1: The A-to-B and B-to-A paths are each 18 bits wide and fully independent. Both can be in different modes in the same cycle without affecting each other.
- R2: While a path's latch-enable is high, its output equals its input in the same cycle (transparent), whatever its capture clock does.
- R3: While latch-enable is low, a rising edge of the capture clock stores the input value present at that system-clock edge. The output shows the stored value from the next cycle on.
- R4: While latch-enable is low and the capture clock stays high or stays low, the output keeps the stored value and changes on the input are ignored.
- R5: The B port drive-enable follows the A-to-B output enable, active high, whatever the latch-enable and capture-clock levels are.
- R6: The A port drive-enable is active low: the port drives when the B-to-A enable is 0 and is released when it is 1.
- R7: When latch-enable falls, the output freezes at the input value sampled at the last system-clock edge before the fall. This holds whether the capture clock is high or low at that moment.
- R8: After a freeze with the capture clock high, a later rising edge of the capture clock, with latch-enable still low, replaces the held value.
- R9: Active-low reset clears both stored values to zero and forces both drive-enables off. A capture clock that is already high when reset is released does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_a_i | input | 18 | Data received from the A bus |
| port_b_i | input | 18 | Data received from the B bus |
| ab_le_i | input | 1 | A-to-B latch enable (high = transparent) |
| ab_clk_i | input | 1 | A-to-B capture clock (sampled) |
| ab_oe_i | input | 1 | A-to-B output enable, active high |
| ba_le_i | input | 1 | B-to-A latch enable (high = transparent) |
| ba_clk_i | input | 1 | B-to-A capture clock (sampled) |
| ba_oe_n_i | input | 1 | B-to-A output enable, active low |
| port_b_o | output | 18 | Data to drive onto the B bus |
| port_b_drv_o | output | 1 | B bus drive enable |
| port_a_o | output | 18 | Data to drive onto the A bus |
| port_a_drv_o | output | 1 | A bus drive enable |

## Verification
Two functions can land in the same system cycle. The first case is a latch-enable fall in one direction while the other direction captures on its clock edge. The second case is a latch-enable fall together with a capture-clock level that is already high. The bench provokes both cases. It drops both latch-enables on one edge, with one capture clock low and the other high, and it sweeps captures in both directions at once. It checks each frozen or captured word against the value it drove one cycle earlier, and it checks that a clock that is already high causes no capture.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;

    // Operating mode of one direction in the current cycle.
    typedef enum logic [1:0] {
        MODE_PASS    = 2'd0,   // latch-enable high: transparent
        MODE_CAPTURE = 2'd1,   // latch-enable low, capture clock rising
        MODE_HOLD    = 2'd2    // latch-enable low, capture clock static
    } path_mode_e;

    function automatic path_mode_e pick_mode(input logic le, input logic rise);
        if (le)
            return MODE_PASS;
        else if (rise)
            return MODE_CAPTURE;
        else
            return MODE_HOLD;
    endfunction

endpackage

// File: rtl/xcvr_edge.sv
`timescale 1ns/1ps
module xcvr_edge #(
    parameter bit RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);

    typedef struct packed {
        logic lvl;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.lvl <= RESET_LEVEL;
        else
            st_q <= st_d;
    end

    assign rise_o = lvl_i & ~st_q.lvl;

    // R3: a detected edge lasts exactly one cycle
    p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o)
        else $error("edge detector reported two rises in a row");

endmodule

// File: rtl/xcvr_path.sv
`timescale 1ns/1ps
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int WIDTH   = 18,
    parameter bit OE_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_i,
    input  logic             le_i,
    input  logic             tck_i,
    input  logic             oe_i,
    output logic [WIDTH-1:0] dout_o,
    output logic             en_o
);

    typedef struct packed {
        logic [WIDTH-1:0] held;
    } path_st_t;

    path_st_t   st_d, st_q;
    logic       rise;
    logic       en_raw;
    path_mode_e mode;

    xcvr_edge #(.RESET_LEVEL(1'b1)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (tck_i),
        .rise_o (rise)
    );

    always_comb begin
        mode = pick_mode(le_i, rise);
        st_d = st_q;
        case (mode)
            MODE_PASS:    st_d.held = din_i;
            MODE_CAPTURE: st_d.held = din_i;
            default:      st_d.held = st_q.held;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign dout_o = (mode == MODE_PASS) ? din_i : st_q.held;

    generate
        if (OE_HIGH) begin : g_oe_high
            assign en_raw = oe_i;
        end else begin : g_oe_low
            assign en_raw = ~oe_i;
        end
    endgenerate

    assign en_o = en_raw & rst_n;

    // R3: a capture edge loads the sampled input
    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_i && rise) |=> (dout_o == $past(din_i) || le_i))
        else $error("capture did not load input");

    // R4: no edge and latch closed keeps the value
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_i && !rise) |=> (le_i || $stable(dout_o) || rise))
        else $error("held value changed without an edge");

    // R7: closing the latch freezes the last sampled input
    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(le_i) && !le_i) |-> (dout_o == $past(din_i)))
        else $error("freeze did not keep last transparent value");

endmodule

// File: rtl/xcvr_top.sv
`timescale 1ns/1ps
module xcvr_top #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] port_a_i,
    input  logic [WIDTH-1:0] port_b_i,
    input  logic             ab_le_i,
    input  logic             ab_clk_i,
    input  logic             ab_oe_i,
    input  logic             ba_le_i,
    input  logic             ba_clk_i,
    input  logic             ba_oe_n_i,
    output logic [WIDTH-1:0] port_b_o,
    output logic             port_b_drv_o,
    output logic [WIDTH-1:0] port_a_o,
    output logic             port_a_drv_o
);

    localparam int NDIR = 2;   // index 0: A to B, index 1: B to A

    logic [WIDTH-1:0] din  [NDIR];
    logic [WIDTH-1:0] dout [NDIR];
    logic             le   [NDIR];
    logic             tck  [NDIR];
    logic             oe   [NDIR];
    logic             en   [NDIR];

    assign din[0] = port_a_i;
    assign le[0]  = ab_le_i;
    assign tck[0] = ab_clk_i;
    assign oe[0]  = ab_oe_i;
    assign din[1] = port_b_i;
    assign le[1]  = ba_le_i;
    assign tck[1] = ba_clk_i;
    assign oe[1]  = ba_oe_n_i;

    generate
        for (genvar d = 0; d < NDIR; d++) begin : g_dir
            xcvr_path #(
                .WIDTH   (WIDTH),
                .OE_HIGH (d == 0)
            ) u_path (
                .clk    (clk),
                .rst_n  (rst_n),
                .din_i  (din[d]),
                .le_i   (le[d]),
                .tck_i  (tck[d]),
                .oe_i   (oe[d]),
                .dout_o (dout[d]),
                .en_o   (en[d])
            );
        end
    endgenerate

    assign port_b_o     = dout[0];
    assign port_b_drv_o = en[0];
    assign port_a_o     = dout[1];
    assign port_a_drv_o = en[1];

    // R9: both ports released while reset is asserted
    always_comb begin
        if (!rst_n) begin
            p_reset_off_r9: assert (!port_a_drv_o && !port_b_drv_o)
                else $error("port driven during reset");
        end
    end

endmodule

// File: tb/sim_xcvr_top.sv
`timescale 1ns/1ps
module sim_xcvr_top;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b_in;
    logic         ab_le, ab_ck, ab_oe, ba_le, ba_ck, ba_oe_n;
    logic [W-1:0] b_out, a_out;
    logic         b_drv, a_drv;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    xcvr_top #(.WIDTH(W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .port_a_i     (a_in),
        .port_b_i     (b_in),
        .ab_le_i      (ab_le),
        .ab_clk_i     (ab_ck),
        .ab_oe_i      (ab_oe),
        .ba_le_i      (ba_le),
        .ba_clk_i     (ba_ck),
        .ba_oe_n_i    (ba_oe_n),
        .port_b_o     (b_out),
        .port_b_drv_o (b_drv),
        .port_a_o     (a_out),
        .port_a_drv_o (a_drv)
    );

    function automatic logic [W-1:0] pat(input int i);
        if (i == 0) return '0;
        if (i == 1) return '1;
        return W'((i * 32'h0A5C3 + 32'h1F) ^ (i << 9));
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst_n = 0; a_in = pat(5); b_in = pat(6);
        ab_le = 0; ab_ck = 1; ab_oe = 1; ba_le = 0; ba_ck = 0; ba_oe_n = 0;
        repeat (3) @(negedge clk);
        #1;
        // R9: enables forced off, storage zero during reset
        chk("R9 b_drv in reset", W'(b_drv), W'(0));
        chk("R9 a_drv in reset", W'(a_drv), W'(0));
        chk("R9 b_out in reset", b_out, '0);
        chk("R9 a_out in reset", a_out, '0);
        rst_n = 1;
        step();
        step();
        // R9: ab_ck high through release is not an edge
        chk("R9 no capture on high clk", b_out, '0);
        chk("R9 a_out zero", a_out, '0);

        // R2 R1: transparent sweep both directions at once
        ab_le = 1; ba_le = 1;
        for (int i = 0; i < 20; i++) begin
            a_in = pat(i); b_in = ~pat(i + 3);
            ab_ck = i[0]; ba_ck = i[1];
            #1;
            chk("R2 transparent A to B", b_out, pat(i));
            chk("R1 transparent B to A", a_out, ~pat(i + 3));
            step();
        end

        // R7: freeze with ab clock low and ba clock high
        ab_ck = 0; ba_ck = 1;
        a_in = pat(30); b_in = pat(31);
        step();
        ab_le = 0; ba_le = 0;
        a_in = pat(32); b_in = pat(33);
        #1;
        chk("R7 freeze clk low", b_out, pat(30));
        chk("R7 freeze clk high", a_out, pat(31));
        step();
        chk("R7 freeze kept A to B", b_out, pat(30));
        chk("R7 freeze kept B to A", a_out, pat(31));

        // R8: later rising edge replaces frozen value
        ba_ck = 0; b_in = pat(34);
        step();
        chk("R4 hold after freeze", a_out, pat(31));
        ba_ck = 1; b_in = pat(35);
        step();
        chk("R8 new edge replaces", a_out, pat(35));
        chk("R1 other path untouched", b_out, pat(30));

        // R3 R4: capture sweep in both directions
        ab_ck = 0; ba_ck = 0;
        step();
        for (int i = 0; i < 16; i++) begin
            a_in = pat(i); b_in = ~pat(i);
            ab_ck = 1; ba_ck = 1;
            step();
            chk("R3 capture A to B", b_out, pat(i));
            chk("R3 capture B to A", a_out, ~pat(i));
            a_in = pat(i + 40); b_in = pat(i + 41);
            step();
            chk("R4 hold clk high", b_out, pat(i));
            chk("R4 hold clk high B to A", a_out, ~pat(i));
            ab_ck = 0; ba_ck = 0;
            a_in = pat(i + 50); b_in = pat(i + 51);
            step();
            chk("R4 hold clk low", b_out, pat(i));
            chk("R4 hold clk low B to A", a_out, ~pat(i));
        end

        // R5 R6: enables independent of latch and clock
        for (int k = 0; k < 16; k++) begin
            ab_oe = k[0]; ba_oe_n = k[1];
            ab_le = k[2]; ab_ck = k[3]; ba_le = k[3]; ba_ck = k[2];
            #1;
            chk("R5 B drive enable", W'(b_drv), W'(k[0]));
            chk("R6 A drive enable", W'(a_drv), W'(!k[1]));
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule